// File: doc/BRIEF.md
# Flash Sector Erase and Program Engine

This block models the erase and program behaviour of a NOR flash array held in a small on-chip memory. It accepts commands on a write port. Each command has an 8-bit opcode, a word address and a data word. Two opcodes are recognised. A program opcode merges new data into a stored word with a bitwise AND, so programming can only clear bits. An erase opcode selects the sector that holds the supplied address and sets every word of that sector to all ones.

The array is split into up to four regions. Each region has its own sector count and sector length, which lets a top-boot or bottom-boot layout with mixed sector sizes be built from parameters. A built-in locator turns an address into the base and length of its sector. Sectors are power-of-two sized and aligned to their own length.

An erase keeps the engine busy for a parameterised number of clock cycles. During that time the sector is cleared one word per clock. While busy, a read returns a status word instead of array data: in every byte lane, bit 7 reads 0 and bit 6 inverts on each successive read. A read-only strap prevents any change to the array but leaves the busy and status behaviour unchanged.

Top module: `flash_sector_engine`

## Requirements
- R1: After reset, `busy` is 0, `rd_data` is 0, and every array word reads as all ones.
- R2: When idle, a command with opcode 0x30 makes `busy` rise after that clock edge. Every word of the sector that contains `cmd_addr` then becomes all ones, and no word outside that sector changes. The default geometry, in word addresses, is: 0-47 as three 16-word sectors; 48-55 as one 8-word sector; 56-59 as two 2-word sectors; 60-63 as one 4-word sector.
- R3: A read accepted while `busy` is 1 returns a status word in which bit 7 of every 8-bit lane is 0.
- R4: In the status word, bit 6 of each lane is 0 on the first read after an erase is accepted and inverts on every later read during that erase. All other status bits are 0.
- R5: `busy` stays high for exactly ERASE_CYCLES clock cycles. After that, reads return array data, and two consecutive reads of the same word return the same value.
- R6: When idle, opcode 0xA0 stores (old AND `cmd_data`) at `cmd_addr`. Writing 0x55 and then 0xA5 into a lane leaves 0x05 in that lane.
- R7: While `busy` is 1, every command is ignored, including program and erase. When idle, opcodes other than 0x30 and 0xA0 are also ignored.
- R8: The status word is identical in every byte lane of the data word.
- R9: With `read_only` at 1, neither program nor erase changes the array, but an erase still produces the full busy period and status sequence.
- R10: The sector clear finishes no later than the cycle in which `busy` falls. This requires ERASE_CYCLES to be at least the largest sector length.
- R11: `rd_data` is updated on the clock edge that samples `rd_en` and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| read_only | input | 1 | Blocks all array modification when 1 |
| cmd_en | input | 1 | Command strobe |
| cmd_op | input | 8 | Opcode: 0x30 sector erase, 0xA0 program |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_data | input | LANE_W*LANES | Program data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | LANE_W*LANES | Array word, or status while busy |
| busy | output | 1 | Erase in progress |

## Verification
The bench programs words on both sides of each sector boundary in all four regions, then erases a sector in each region. A locator that picked the wrong region length would either clear a neighbouring word or leave a programmed word inside the sector untouched. It checks the exact status sequence during an erase: zero, then bit 6 set in both lanes, then zero again. A design that toggled per cycle instead of per read, or that set bit 7, would break that pattern. It issues program and erase commands while busy and with the read-only strap set, expecting the array to be left unchanged. It also counts the busy cycles, which would expose an off-by-one in the timer.

// File: rtl/flash_sector_engine.sv
module flash_sector_engine #(
  parameter int LANE_W       = 8,
  parameter int LANES        = 2,
  parameter int ADDR_W       = 6,
  parameter int ERASE_CYCLES = 100,
  parameter int R0_CNT = 3, parameter int R0_LEN = 16,
  parameter int R1_CNT = 1, parameter int R1_LEN = 8,
  parameter int R2_CNT = 2, parameter int R2_LEN = 2,
  parameter int R3_CNT = 1, parameter int R3_LEN = 4,
  parameter logic [7:0] OP_ERASE = 8'h30,
  parameter logic [7:0] OP_PROG  = 8'hA0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      read_only,
  input  logic                      cmd_en,
  input  logic [7:0]                cmd_op,
  input  logic [ADDR_W-1:0]         cmd_addr,
  input  logic [LANE_W*LANES-1:0]   cmd_data,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [LANE_W*LANES-1:0]   rd_data,
  output logic                      busy
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int TW     = $clog2(ERASE_CYCLES + 1);
  localparam int RCNT [4] = '{R0_CNT, R1_CNT, R2_CNT, R3_CNT};
  localparam int RLEN [4] = '{R0_LEN, R1_LEN, R2_LEN, R3_LEN};

  logic [DATA_W-1:0] mem [DEPTH];
  logic [TW-1:0]     tmr_q;
  logic [ADDR_W-1:0] clr_ptr;
  logic [ADDR_W:0]   clr_left;
  logic              tgl_q;

  logic [ADDR_W:0]   sec_len;
  logic [ADDR_W-1:0] sec_base;
  logic [DATA_W-1:0] stat_word;
  logic              do_erase, do_prog;

  always_comb begin
    int acc;
    acc = 0;
    sec_len = '0;
    for (int i = 0; i < 4; i++) begin
      if (int'(cmd_addr) >= acc && int'(cmd_addr) < acc + RCNT[i] * RLEN[i])
        sec_len = (ADDR_W+1)'(RLEN[i]);
      acc = acc + RCNT[i] * RLEN[i];
    end
  end

  assign sec_base  = cmd_addr & ~ADDR_W'(sec_len - 1'b1);
  assign stat_word = {LANES{1'b0, tgl_q, {(LANE_W-2){1'b0}}}};
  assign do_erase  = !busy && cmd_en && cmd_op == OP_ERASE;
  assign do_prog   = !busy && cmd_en && cmd_op == OP_PROG && !read_only;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tmr_q    <= '0;
      clr_ptr  <= '0;
      clr_left <= '0;
    end else if (do_erase) begin
      busy     <= 1'b1;
      tmr_q    <= TW'(ERASE_CYCLES - 1);
      clr_ptr  <= sec_base;
      clr_left <= sec_len;
    end else if (busy) begin
      if (tmr_q == '0) busy <= 1'b0;
      else             tmr_q <= tmr_q - 1'b1;
      if (clr_left != '0) begin
        clr_ptr  <= clr_ptr + 1'b1;
        clr_left <= clr_left - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (busy && clr_left != '0) begin
      if (!read_only) mem[clr_ptr] <= '1;
    end else if (do_prog) begin
      mem[cmd_addr] <= mem[cmd_addr] & cmd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      tgl_q   <= 1'b0;
    end else begin
      if (do_erase) tgl_q <= 1'b0;
      if (rd_en) begin
        if (busy) begin
          rd_data <= stat_word;
          tgl_q   <= ~tgl_q;
        end else begin
          rd_data <= mem[rd_addr];
        end
      end
    end
  end

  p_erase_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_en && cmd_op == OP_ERASE) |=> busy);

  p_dq7_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (rd_data[LANE_W-1] == 1'b0));

  p_dq6_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en && $past(busy && rd_en)) |=> (rd_data[LANE_W-2] != $past(rd_data[LANE_W-2])));

  p_lane_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |=> (rd_data == {LANES{rd_data[LANE_W-1:0]}}));

  p_clear_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (clr_left == '0));

  p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !$past(!rst_n)) |=> $stable(rd_data));
endmodule

// File: tb/flash_sector_engine_tb_top.sv
module flash_sector_engine_tb_top;
  localparam int ECYC = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        read_only = 1'b0;
  logic        cmd_en = 1'b0;
  logic [7:0]  cmd_op = '0;
  logic [5:0]  cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        busy;

  always #5 clk = ~clk;

  flash_sector_engine #(.ERASE_CYCLES(ECYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .read_only(read_only), .cmd_en(cmd_en),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  logic [15:0] model [64];
  logic m_busy = 1'b0;
  logic m_tgl = 1'b0;
  logic pend = 1'b0;
  bit done = 0;

  always @(posedge clk) pend <= rd_en;

  always @(negedge clk) begin
    if (pend) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data: actual %h expected none", rd_data);
      end else begin
        item_t it;
        it = q.pop_front();
        if (rd_data !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, rd_data, it.exp);
        end
      end
    end
  end

  function automatic int slen(int a);
    if (a < 48) return 16;
    if (a < 56) return 8;
    if (a < 60) return 2;
    return 4;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(int a, string tag);
    rd_en = 1'b1; rd_addr = 6'(a);
    if (m_busy) begin
      q.push_back('{{2{1'b0, m_tgl, 6'b0}}, tag});
      m_tgl = ~m_tgl;
    end else q.push_back('{model[a], tag});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic cmd(logic [7:0] op, int a, logic [15:0] d);
    cmd_en = 1'b1; cmd_op = op; cmd_addr = 6'(a); cmd_data = d;
    @(negedge clk);
    cmd_en = 1'b0;
    if (!m_busy && !read_only && op == 8'hA0) model[a] = model[a] & d;
    if (!m_busy && op == 8'h30) begin
      int b;
      b = a - (a % slen(a));
      if (!read_only) for (int i = b; i < b + slen(a); i++) model[i] = 16'hFFFF;
      m_busy = 1'b1; m_tgl = 1'b0;
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    m_busy = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk(rd_data == 16'h0, "R1 rd_data reset", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    rd(0, "R1 word 0 ones"); rd(63, "R1 word 63 ones");

    cmd(8'hA0, 3, 16'h5555); cmd(8'hA0, 3, 16'hA5A5);
    rd(3, "R6 and 55 then A5");
    cmd(8'hA0, 4, 16'h00FF); cmd(8'hA0, 4, 16'hFF0F);
    rd(4, "R6 and merge");
    cmd(8'h12, 6, 16'h0000);
    rd(6, "R7 unknown opcode ignored");
    repeat (2) @(negedge clk);
    chk(rd_data == 16'hFFFF, "R11 rd_data held", rd_data, 16'hFFFF);

    cmd(8'hA0, 5, 16'h0000); cmd(8'hA0, 47, 16'h0000); cmd(8'hA0, 48, 16'h0000);
    cmd(8'hA0, 55, 16'h0000); cmd(8'hA0, 56, 16'h0000); cmd(8'hA0, 50, 16'h1234);
    cmd(8'h30, 50, 16'h0);
    chk(busy == 1'b1, "R2 busy after erase", busy, 1);
    rd(50, "R3 R4 first status"); rd(0, "R4 R8 second status"); rd(5, "R4 third status");
    cmd(8'hA0, 20, 16'h0000);
    cmd(8'h30, 5, 16'h0);
    wait_idle();
    rd(50, "R2 erased word"); rd(50, "R5 repeat read");
    rd(48, "R2 sector low"); rd(55, "R2 sector high");
    rd(47, "R2 below sector kept"); rd(56, "R2 above sector kept");
    rd(20, "R7 program while busy ignored"); rd(5, "R7 erase while busy ignored");

    cmd(8'hA0, 57, 16'h0000); cmd(8'hA0, 58, 16'h0000);
    cmd(8'hA0, 59, 16'h0000); cmd(8'hA0, 60, 16'h0000);
    cmd(8'h30, 59, 16'h0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    m_busy = 1'b0;
    chk(n == ECYC, "R5 busy length", n, ECYC);
    rd(57, "R2 2-word sector neighbour"); rd(58, "R2 2-word low");
    rd(59, "R2 2-word high"); rd(60, "R2 next region kept");

    cmd(8'hA0, 63, 16'h0F0F);
    cmd(8'h30, 62, 16'h0);
    wait_idle();
    rd(60, "R2 4-word low"); rd(63, "R2 4-word high"); rd(59, "R2 below 4-word");

    cmd(8'hA0, 15, 16'h0000); cmd(8'hA0, 16, 16'h0000);
    cmd(8'hA0, 31, 16'h0000); cmd(8'hA0, 32, 16'h0000);
    cmd(8'h30, 20, 16'h0);
    wait_idle();
    rd(16, "R2 16-word low"); rd(31, "R2 16-word high");
    rd(15, "R2 below 16-word"); rd(32, "R2 above 16-word");

    cmd(8'hA0, 40, 16'h0000);
    read_only = 1'b1;
    cmd(8'hA0, 41, 16'h0000);
    cmd(8'h30, 40, 16'h0);
    chk(busy == 1'b1, "R9 busy when read-only", busy, 1);
    rd(40, "R9 status first"); rd(40, "R9 status second");
    wait_idle();
    rd(40, "R9 erase blocked"); rd(41, "R9 program blocked");
    read_only = 1'b0;

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "scoreboard drained", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule